// File: doc/BRIEF.md
# Signed-Overflow Trapping Add/Subtract Unit

This unit performs 32-bit integer addition and subtraction for a simple integer datapath. Each operation takes a first operand and either a second register operand or a 16-bit immediate. The immediate is sign-extended to full width. The unit checks every operation for two's-complement overflow. Only the trapping variants act on that check: a trapping operation that overflows raises a one-cycle exception pulse, blocks the destination write and copies the address of the offending instruction into an exception program counter (EPC). The non-trapping variants return the wrapped result and write it back, whatever the sign bits show.

A request is presented for one clock with `op_valid` high. Its result, write enable and exception pulse appear together on the next cycle. A small controller holds three states:

- `ST_IDLE`: no result is presented.
- `ST_ISSUE`: a result that may be written back is presented.
- `ST_FAULT`: a trapped result is presented.

On each clock the controller moves as follows:

- From any state it enters `ST_FAULT` when a valid trapping operation overflows.
- From any state it enters `ST_ISSUE` when any other valid operation arrives.
- From any state it enters `ST_IDLE` when no operation arrives.

Because of this, back-to-back operations are accepted on every cycle. A separate read port copies the EPC into a data register so that software can move it into a general register.

Top module: `addtrap_unit`

## Requirements
- R1: `op_sel` is decoded as three independent bits: bit 0 selects the immediate in place of `src_b`, bit 1 selects subtraction (`src_a - operand`) in place of addition, and bit 2 marks the non-trapping variant. `result` is the sum or difference modulo 2^32.
- R2: When bit 0 of `op_sel` is set, `imm16` is sign-extended to 32 bits (bit 15 copied into bits 31..16) and `src_b` has no effect on `result`.
- R3: For addition, overflow is flagged when both operands share a sign and the result sign differs from it.
- R4: For subtraction, overflow is flagged when a non-negative value minus a negative value gives a negative result, or a negative value minus a non-negative value gives a non-negative result.
- R5: A trapping operation (bit 2 of `op_sel` clear) that overflows drives `exc_pulse` high, and from that same cycle `epc_out` holds the `inst_addr` presented with the operation.
- R6: `wr_en` is high with each presented result unless that result trapped, in which case `wr_en` is low.
- R7: A non-trapping operation (bit 2 set) never raises `exc_pulse` and always asserts `wr_en`, even when the same bit pattern overflows.
- R8: `epc_out` keeps its value until the next trap or reset. A request on `mfc_req` loads `mfc_data` with the EPC on the following cycle and leaves the EPC unchanged.
- R9: `res_valid`, `result`, `wr_en` and `exc_pulse` belong to the cycle after the one in which `op_valid` was high. `exc_pulse` lasts one cycle per trapping operation, and with no operation `res_valid`, `wr_en` and `exc_pulse` are low.
- R10: After reset `res_valid`, `wr_en`, `exc_pulse`, `epc_out` and `mfc_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_sel | input | 3 | Bit 0 immediate, bit 1 subtract, bit 2 non-trapping |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate, sign-extended when selected |
| inst_addr | input | 32 | Address of the instruction issuing the operation |
| mfc_req | input | 1 | Request to copy the EPC onto `mfc_data` |
| res_valid | output | 1 | A result is presented this cycle |
| result | output | 32 | Wrapped sum or difference |
| wr_en | output | 1 | Destination write permitted |
| exc_pulse | output | 1 | One-cycle overflow exception |
| epc_out | output | 32 | Exception program counter |
| mfc_data | output | 32 | EPC copy returned by the read port |

## Verification
The bench targets the sign-boundary operands, such as 0x7FFFFFFF plus one, 0x80000000 minus one, the sum of two 0x80000000 values, and subtraction of the most negative value. A design that inferred overflow from the carry out, or that ignored the inversion of the subtrahend, would trap or stay silent on the wrong one of these. The same overflowing patterns are replayed with the non-trapping variants, where any pulse or dropped write exposes a decode of the wrong opcode bit. The bench also checks negative immediates with a garbage `src_b`, which catches zero extension or a leaking register operand. Finally it runs back-to-back trapping and clean operations and follows them with EPC reads. A stretched pulse, an EPC overwritten by a clean operation, or a read that disturbs the EPC each shows up as a mismatch.

// File: rtl/addtrap_pkg.sv
package addtrap_pkg;
    localparam int OP_W       = 3;
    localparam int OPB_IMM    = 0;
    localparam int OPB_SUB    = 1;
    localparam int OPB_NOTRAP = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/addtrap_opsel.sv
module addtrap_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        opnd_b  = use_imm ? imm_ext : src_b;
    end
endmodule

// File: rtl/addtrap_core.sv
module addtrap_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff = do_sub ? ~b : b;
        sum   = a + b_eff + DATA_W'(do_sub);
        // Overflow: same-sign addends giving a result of the other sign.
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/addtrap_epc.sv
module addtrap_epc #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] epc_q,
    output logic [ADDR_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q <= '0;
        end else if (capture) begin
            epc_q <= addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= epc_q;
        end
    end

    // R8: the read port returns the EPC seen at the request edge
    assert_mfc_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_data == $past(epc_q)));
endmodule

// File: rtl/addtrap_unit.sv
module addtrap_unit
    import addtrap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic              mfc_req,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              exc_pulse,
    output logic [ADDR_W-1:0] epc_out,
    output logic [ADDR_W-1:0] mfc_data
);
    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              ovf;
    logic              trap;
    logic [DATA_W-1:0] result_q;

    addtrap_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .src_b   (src_b),
        .imm     (imm16),
        .use_imm (op_sel[OPB_IMM]),
        .opnd_b  (opnd_b)
    );

    addtrap_core #(.DATA_W(DATA_W)) u_core (
        .a      (src_a),
        .b      (opnd_b),
        .do_sub (op_sel[OPB_SUB]),
        .sum    (sum),
        .ovf    (ovf)
    );

    assign trap = op_valid && ovf && !op_sel[OPB_NOTRAP];

    addtrap_epc #(.ADDR_W(ADDR_W)) u_epc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (trap),
        .addr_in (inst_addr),
        .rd_req  (mfc_req),
        .epc_q   (epc_out),
        .rd_data (mfc_data)
    );

    // Next-state selection
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_FAULT: begin
                if (trap) begin
                    state_d = ST_FAULT;
                end else if (op_valid) begin
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (op_valid) begin
                result_q <= sum;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        res_valid = 1'b0;
        wr_en     = 1'b0;
        exc_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                res_valid = 1'b1;
                wr_en     = 1'b1;
            end
            ST_FAULT: begin
                res_valid = 1'b1;
                exc_pulse = 1'b1;
            end
            default: ;
        endcase
        result = result_q;
    end

    // R5: the EPC holds the address issued with the faulting operation
    assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> (epc_out == $past(inst_addr)));

    // R6: a trapped result is never written back
    assert_no_write_on_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> (!wr_en && res_valid));

    // R7: non-trapping variants never raise the exception
    assert_unsigned_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel[OPB_NOTRAP]) |=> (!exc_pulse && wr_en));

    // R8: the EPC only moves in a trap cycle
    assert_epc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pulse |-> $stable(epc_out));

    // R9: no request, no result on the next cycle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !exc_pulse && !wr_en));
endmodule

// File: tb/tb_addtrap_unit.sv
module tb_addtrap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] inst_addr = '0;
    logic        mfc_req = 1'b0;
    logic        res_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        exc_pulse;
    logic [31:0] epc_out;
    logic [31:0] mfc_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_epc = '0;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic        exc;
        logic [31:0] epc;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    addtrap_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .imm16(imm16), .inst_addr(inst_addr),
        .mfc_req(mfc_req), .res_valid(res_valid), .result(result),
        .wr_en(wr_en), .exc_pulse(exc_pulse), .epc_out(epc_out),
        .mfc_data(mfc_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: computes the expectation from the requirements and queues it
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [31:0] addr, input string tag);
        logic [31:0] bo;
        longint      sa, sb, r;
        bit          ovf, trp;
        exp_t        e;
        bo  = op[0] ? {{16{imm[15]}}, imm} : b;
        sa  = longint'($signed(a));
        sb  = longint'($signed(bo));
        r   = op[1] ? (sa - sb) : (sa + sb);
        ovf = (r > 64'sd2147483647) || (r < -64'sd2147483648);
        trp = ovf && !op[2];
        if (trp) model_epc = addr;
        e.res = op[1] ? (a - bo) : (a + bo);
        e.wr  = !trp;
        e.exc = trp;
        e.epc = model_epc;
        e.tag = tag;
        @(negedge clk);
        sbq.push_back(e);
        op_valid  = 1'b1;
        op_sel    = op;
        src_a     = a;
        src_b     = b;
        imm16     = imm;
        inst_addr = addr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid  = 1'b0;
            src_a     = 32'hDEAD_BEEF;
            inst_addr = 32'hFFFF_FFF0;
        end
    endtask

    task automatic mfc_read(input string tag);
        @(negedge clk);
        mfc_req = 1'b1;
        @(negedge clk);
        mfc_req = 1'b0;
        chk(mfc_data == model_epc, {tag, " R8 mfc_data"}, mfc_data, model_epc);
        chk(epc_out == model_epc, {tag, " R8 epc unchanged by read"}, epc_out, model_epc);
    endtask

    // Monitor: compares each presented result against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (res_valid) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R9 unexpected res_valid", {31'd0, res_valid}, 32'd0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(result == e.res, {e.tag, " result"}, result, e.res);
                        chk(wr_en == e.wr, {e.tag, " wr_en"}, {31'd0, wr_en}, {31'd0, e.wr});
                        chk(exc_pulse == e.exc, {e.tag, " exc_pulse"}, {31'd0, exc_pulse}, {31'd0, e.exc});
                        chk(epc_out == e.epc, {e.tag, " epc_out"}, epc_out, e.epc);
                    end
                end else begin
                    chk(!exc_pulse && !wr_en, "R9 idle outputs quiet",
                        {30'd0, exc_pulse, wr_en}, 32'd0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R10 reset res_valid", {31'd0, res_valid}, 32'd0);
        chk(wr_en == 1'b0, "R10 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk(exc_pulse == 1'b0, "R10 reset exc_pulse", {31'd0, exc_pulse}, 32'd0);
        chk(epc_out == 32'd0, "R10 reset epc_out", epc_out, 32'd0);
        chk(mfc_data == 32'd0, "R10 reset mfc_data", mfc_data, 32'd0);

        // Additions
        issue(3'b000, 32'd5, 32'd7, 16'h0, 32'h0000_0100, "R1 add plain");
        issue(3'b000, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h0000_0104, "R3 R5 R6 add pos+pos");
        issue(3'b000, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h0000_0108, "R3 R5 add neg+neg");
        issue(3'b000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0000_010C, "R3 add mixed signs");
        issue(3'b100, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h0000_0110, "R7 addu wraps");
        idle(2);
        mfc_read("after adds");

        // Subtractions
        issue(3'b010, 32'd5, 32'd9, 16'h0, 32'h0000_0200, "R1 R4 sub negative result");
        issue(3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h0000_0204, "R4 R5 sub pos-neg");
        issue(3'b010, 32'h8000_0000, 32'd1, 16'h0, 32'h0000_0208, "R4 R5 sub neg-pos");
        issue(3'b010, 32'd0, 32'h8000_0000, 16'h0, 32'h0000_020C, "R4 sub zero-minneg");
        issue(3'b010, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 32'h0000_0210, "R4 sub neg-minneg");
        issue(3'b110, 32'h8000_0000, 32'd1, 16'h0, 32'h0000_0214, "R7 subu wraps");
        idle(1);

        // Immediates, src_b carries garbage
        issue(3'b001, 32'd10, 32'h1234_5678, 16'hFFFE, 32'h0000_0300, "R2 addi negative imm");
        issue(3'b001, 32'h8000_0000, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0304, "R2 R3 R5 addi underflow");
        issue(3'b001, 32'h7FFF_FFF0, 32'h0, 16'h0010, 32'h0000_0308, "R2 R3 addi overflow");
        issue(3'b101, 32'h7FFF_FFF0, 32'hAAAA_AAAA, 16'h0010, 32'h0000_030C, "R2 R7 addiu wraps");
        issue(3'b011, 32'd3, 32'h5555_5555, 16'h8000, 32'h0000_0310, "R1 R2 sub imm");
        idle(2);
        mfc_read("after immediates");

        // Back-to-back: trap, clean, trap, clean
        issue(3'b000, 32'h4000_0000, 32'h4000_0000, 16'h0, 32'h0000_0400, "R5 R9 b2b trap one");
        issue(3'b000, 32'd1, 32'd2, 16'h0, 32'h0000_0404, "R8 R9 b2b clean keeps epc");
        issue(3'b010, 32'h8000_0001, 32'd2, 16'h0, 32'h0000_0408, "R5 R9 b2b trap two");
        issue(3'b110, 32'h8000_0001, 32'd2, 16'h0, 32'h0000_040C, "R7 R8 b2b subu keeps epc");
        idle(3);
        mfc_read("after back-to-back");
        mfc_read("second read");

        idle(2);
        chk(sbq.size() == 0, "R9 all results presented", sbq.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule